// File: doc/BRIEF.md
# CPU Interrupt and Bus-Request Sequencer

This block sits beside the control unit of an 8-bit CPU core. At each machine-cycle and instruction boundary it decides what happens next. The core may carry on, hand its bus to an external master, take a non-maskable interrupt, or take a maskable interrupt. The control unit reports boundaries with a cycle-end strobe and an instruction-end strobe. A stall input stretches the current cycle. The control unit also forwards the enable-flag commands and the halt command decoded from the instruction stream.

Priority is fixed. A bus request wins over the non-maskable interrupt, and the non-maskable interrupt wins over the maskable one. Bus requests are looked at on every valid cycle end. Interrupts are looked at only when an instruction ends.

A non-maskable interrupt produces a one-clock restart strobe with the fixed vector 0x0066. A maskable interrupt first runs an acknowledge cycle of several clocks with both acknowledge controls high, so that the device can drive its response. After that cycle the block issues a restart strobe with a configurable vector. While halted, the control unit keeps fetching no-operation cycles so that memory refresh continues. Those fetches produce the instruction ends at which the wake-up interrupt is taken.

Top module: `irq_busreq_seq`

## Requirements
- R1: A power-on reset clears bus acknowledge, both acknowledge controls, the restart strobe, halt, any pending non-maskable request and the enable flag. After reset a maskable request at an instruction end is not accepted. bus_oe is 1 after reset.
- R2: When running, bus_req is sampled at every valid cycle end (cyc_end=1 and stall=0), with or without ins_end. If it is high, bus_ack goes to 1 and bus_oe goes to 0 in the clock after that edge. With cyc_end=0 the request is not sampled.
- R3: While the bus is granted, bus_ack stays 1 and bus_oe stays 0 as long as bus_req is 1. In the clock after bus_req is seen at 0, bus_ack returns to 0 and bus_oe to 1. Cycle and instruction strobes are ignored while the bus is granted.
- R4: If bus_req is high at an instruction end, no interrupt is accepted at that boundary, even when one is enabled and pending.
- R5: A rising edge on nmi_req is held pending until the next valid instruction end. It is then accepted whatever the enable flag holds. In the following clock, vec_load is 1 for one clock with vec_addr = 0x0066.
- R6: When a non-maskable request is pending and an enabled maskable request is present at the same instruction end, the non-maskable one is taken and no acknowledge cycle starts.
- R7: A maskable request is accepted only at a valid instruction end with the enable flag at 1. From the next clock, ack_m1 and ack_iorq are both 1 for ACK_CYC unstalled clocks (default 4). In the clock after the last of these, vec_load is 1 with vec_addr = INT_VEC (default 0x0038).
- R8: While stall=1, a cycle end samples neither the bus request nor the interrupts. A stalled clock inside the acknowledge cycle lengthens that cycle by one clock.
- R9: Accepting any interrupt clears the enable flag. A non-maskable acceptance first copies the flag into a shadow bit, and nmi_ret=1 restores the flag from that shadow bit.
- R10: ie_set=1 sets the enable flag and ie_clr=1 clears it. When both are 1 in the same clock, clear wins.
- R11: halt_cmd=1 sets halted in the next clock. halted stays 1 across instruction ends at which no interrupt is accepted. It drops in the clock after a non-maskable or enabled maskable interrupt is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, active high, asynchronous |
| bus_req | input | 1 | External master requests the bus |
| nmi_req | input | 1 | Non-maskable interrupt request, edge sensitive |
| int_req | input | 1 | Maskable interrupt request, level sensitive |
| stall | input | 1 | Addressed device not ready; stretches the cycle |
| cyc_end | input | 1 | Last clock of a machine cycle |
| ins_end | input | 1 | Last machine cycle of an instruction (meaningful with cyc_end) |
| ie_set | input | 1 | Set the interrupt enable flag |
| ie_clr | input | 1 | Clear the interrupt enable flag |
| nmi_ret | input | 1 | Restore the enable flag from the shadow bit |
| halt_cmd | input | 1 | Halt instruction executed |
| bus_ack | output | 1 | Bus granted to the external master |
| bus_oe | output | 1 | Core may drive address, data and strobes |
| ack_m1 | output | 1 | Acknowledge-cycle fetch control |
| ack_iorq | output | 1 | Acknowledge-cycle I/O control |
| vec_load | output | 1 | One-clock strobe: load vec_addr into the program counter |
| vec_addr | output | ADDR_W | Restart address |
| halted | output | 1 | Core is halted and issues no-operation fetches |

## Verification
The interesting coincidences are boundaries where two decisions compete in one clock. The bench raises a bus request at an instruction end while an enabled maskable request is present. It judges the outcome by bus_ack rising with no acknowledge cycle following. It also raises a pending non-maskable edge together with an enabled maskable request while the core is halted. That case passes only if the restart strobe carries 0x0066, halted falls in the same clock, and ack_m1 stays low. Later probes of the enable flag then show that the shadow bit was written by that same acceptance.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_ACK = 2'd1,
        ST_BUS = 2'd2
    } seq_state_e;
endpackage

// File: rtl/nmi_capture.sv
module nmi_capture (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic taken,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.prev = nmi_req;
        // a fresh edge during service re-arms the latch
        c_d.pend = (c_q.pend & ~taken) | (nmi_req & ~c_q.prev);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign pending = c_q.pend;
endmodule

// File: rtl/ie_ctrl.sv
module ie_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic ret_cmd,
    input  logic take_nmi,
    input  logic take_int,
    output logic ie
);
    typedef struct packed {
        logic en;
        logic shadow;
    } ie_t;

    ie_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (take_nmi) begin
            f_d.shadow = f_q.en;
            f_d.en     = 1'b0;
        end else if (take_int) begin
            f_d.en = 1'b0;
        end else if (ret_cmd) begin
            f_d.en = f_q.shadow;
        end else if (clr_cmd) begin
            f_d.en = 1'b0;
        end else if (set_cmd) begin
            f_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign ie = f_q.en;
endmodule

// File: rtl/irq_busreq_seq.sv
module irq_busreq_seq #(
    parameter int                 ADDR_W  = 16,
    parameter int                 ACK_CYC = 4,
    parameter logic [ADDR_W-1:0]  INT_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic              stall,
    input  logic              cyc_end,
    input  logic              ins_end,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              nmi_ret,
    input  logic              halt_cmd,
    output logic              bus_ack,
    output logic              bus_oe,
    output logic              ack_m1,
    output logic              ack_iorq,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              halted
);
    import seq_pkg::*;

    localparam int                CW      = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
    localparam logic [CW-1:0]     CNT_TOP = CW'(ACK_CYC - 1);
    localparam logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(16'h0066);

    typedef struct packed {
        seq_state_e        st;
        logic [CW-1:0]     cnt;
        logic              vld;
        logic [ADDR_W-1:0] vec;
        logic              hlt;
    } seq_t;

    seq_t s_d, s_q;

    logic nmi_pend, ie;
    logic cyc_ok, in_run, ins_ok, bus_take, take_nmi, take_int;

    assign cyc_ok   = cyc_end & ~stall;
    assign in_run   = (s_q.st == ST_RUN);
    assign bus_take = in_run & cyc_ok & bus_req;
    assign ins_ok   = in_run & cyc_ok & ins_end & ~bus_req;
    assign take_nmi = ins_ok & nmi_pend;
    assign take_int = ins_ok & ~nmi_pend & int_req & ie;

    nmi_capture u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_req (nmi_req),
        .taken   (take_nmi),
        .pending (nmi_pend)
    );

    ie_ctrl u_ie (
        .clk      (clk),
        .rst      (rst),
        .set_cmd  (ie_set),
        .clr_cmd  (ie_clr),
        .ret_cmd  (nmi_ret),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .ie       (ie)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        unique case (s_q.st)
            ST_RUN: begin
                if (halt_cmd && !take_nmi && !take_int) s_d.hlt = 1'b1;
                if (bus_take) begin
                    s_d.st = ST_BUS;
                end else if (take_nmi) begin
                    s_d.vld = 1'b1;
                    s_d.vec = NMI_VEC;
                    s_d.hlt = 1'b0;
                end else if (take_int) begin
                    s_d.st  = ST_ACK;
                    s_d.cnt = CNT_TOP;
                    s_d.hlt = 1'b0;
                end
            end
            ST_ACK: begin
                if (!stall) begin
                    if (s_q.cnt == '0) begin
                        s_d.st  = ST_RUN;
                        s_d.vld = 1'b1;
                        s_d.vec = INT_VEC;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            end
            ST_BUS: begin
                if (!bus_req) s_d.st = ST_RUN;
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s_q.st  <= ST_RUN;
            s_q.cnt <= '0;
            s_q.vld <= 1'b0;
            s_q.vec <= '0;
            s_q.hlt <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ack  = (s_q.st == ST_BUS);
    assign bus_oe   = (s_q.st != ST_BUS);
    assign ack_m1   = (s_q.st == ST_ACK);
    assign ack_iorq = (s_q.st == ST_ACK);
    assign vec_load = s_q.vld;
    assign vec_addr = s_q.vec;
    assign halted   = s_q.hlt;
endmodule

// File: rtl/irq_busreq_seq_chk.sv
module irq_busreq_seq_chk #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] INT_VEC = 16'h0038
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              int_req,
    input logic              stall,
    input logic              cyc_end,
    input logic              ins_end,
    input logic              bus_ack,
    input logic              bus_oe,
    input logic              ack_m1,
    input logic              vec_load,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              halted
);
    // R2
    grant_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && !ack_m1 && cyc_end && !stall && bus_req) |=> bus_ack);

    // R8
    stall_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && !ack_m1 && stall && bus_req) |=> !bus_ack);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && bus_req) |=> bus_ack);

    // R3
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_req) |=> (!bus_ack && bus_oe));

    // R4
    bus_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack && !ack_m1 && cyc_end && !stall && bus_req) |=> (!ack_m1 && !vec_load));

    // R7
    ack_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_m1) |-> $past(int_req && cyc_end && ins_end && !stall && !bus_req));

    // R8
    ack_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_m1 && stall) |=> ack_m1);

    // R5
    nmi_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_load && !$past(ack_m1)) |-> (vec_addr == ADDR_W'(16'h0066)));

    // R7
    int_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_load && $past(ack_m1)) |-> (vec_addr == INT_VEC));

    // R11
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> (vec_load || ack_m1));
endmodule

bind irq_busreq_seq irq_busreq_seq_chk #(
    .ADDR_W  (ADDR_W),
    .INT_VEC (INT_VEC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .int_req  (int_req),
    .stall    (stall),
    .cyc_end  (cyc_end),
    .ins_end  (ins_end),
    .bus_ack  (bus_ack),
    .bus_oe   (bus_oe),
    .ack_m1   (ack_m1),
    .vec_load (vec_load),
    .vec_addr (vec_addr),
    .halted   (halted)
);

// File: tb/test_irq_busreq_seq.sv
`timescale 1ns/1ps
module test_irq_busreq_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, nmi_req = 1'b0, int_req = 1'b0, stall = 1'b0;
    logic        cyc_end = 1'b0, ins_end = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
    logic        nmi_ret = 1'b0, halt_cmd = 1'b0;
    logic        bus_ack, bus_oe, ack_m1, ack_iorq, vec_load, halted;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_busreq_seq i_irq_busreq_seq (
        .clk(clk), .rst(rst), .bus_req(bus_req), .nmi_req(nmi_req),
        .int_req(int_req), .stall(stall), .cyc_end(cyc_end), .ins_end(ins_end),
        .ie_set(ie_set), .ie_clr(ie_clr), .nmi_ret(nmi_ret), .halt_cmd(halt_cmd),
        .bus_ack(bus_ack), .bus_oe(bus_oe), .ack_m1(ack_m1), .ack_iorq(ack_iorq),
        .vec_load(vec_load), .vec_addr(vec_addr), .halted(halted)
    );

    // in = {bus_req, nmi, int, stall, cyc, ins, set, clr, ret, halt}
    // ex = {bus_ack, m1/iorq, vec_load, vec_is_nmi, halted}
    typedef struct packed {
        logic [7:0] req;
        logic [9:0] in;
        logic [4:0] ex;
    } row_t;

    localparam int NROWS = 32;
    localparam row_t TBL [NROWS] = '{
        '{8'd2,  10'b1000000000, 5'b00000},  // R2 no cycle end
        '{8'd2,  10'b1000100000, 5'b10000},  // R2 grant
        '{8'd3,  10'b1100110000, 5'b10000},  // R3 strobes ignored, nmi edge
        '{8'd3,  10'b0100000000, 5'b00000},  // R3 release
        '{8'd5,  10'b0000110000, 5'b00110},  // R5 nmi with ie=0
        '{8'd10, 10'b0000001100, 5'b00000},  // R10 set+clr
        '{8'd10, 10'b0010110000, 5'b00000},  // R10 clear won
        '{8'd10, 10'b0000001000, 5'b00000},  // R10 set
        '{8'd4,  10'b1010110000, 5'b10000},  // R4 bus beats int
        '{8'd3,  10'b0010110000, 5'b00000},  // R3 drop, ins end ignored
        '{8'd8,  10'b0011110000, 5'b00000},  // R8 stalled boundary
        '{8'd7,  10'b0010110000, 5'b01000},  // R7 accept
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd8,  10'b0001000000, 5'b01000},  // R8 stall in ack
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd7,  10'b0000000000, 5'b00100},  // R7 vector
        '{8'd9,  10'b0010110000, 5'b00000},  // R9 ie cleared
        '{8'd9,  10'b0000001000, 5'b00000},  // R9 set again
        '{8'd11, 10'b0000000001, 5'b00001},  // R11 halt
        '{8'd11, 10'b0100110000, 5'b00001},  // R11 stays, nmi edge
        '{8'd6,  10'b0110110000, 5'b00110},  // R6 nmi beats int, wake
        '{8'd9,  10'b0010110000, 5'b00000},  // R9 ie cleared by nmi
        '{8'd9,  10'b0000000010, 5'b00000},  // R9 restore
        '{8'd9,  10'b0010110000, 5'b01000},  // R9 shadow was 1
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd7,  10'b0000000000, 5'b01000},  // R7
        '{8'd7,  10'b0000000000, 5'b00100},  // R7 vector
        '{8'd8,  10'b1001100000, 5'b00000},  // R8 stall blocks bus
        '{8'd2,  10'b1000100000, 5'b10000},  // R2
        '{8'd3,  10'b0000000000, 5'b00000}   // R3
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] v);
        {bus_req, nmi_req, int_req, stall, cyc_end, ins_end,
         ie_set, ie_clr, nmi_ret, halt_cmd} = v;
    endtask

    task automatic chk_idle(input string req);
        chk(req, "bus_ack", {15'd0, bus_ack}, 16'd0);
        chk(req, "bus_oe", {15'd0, bus_oe}, 16'd1);
        chk(req, "ack_m1", {15'd0, ack_m1}, 16'd0);
        chk(req, "ack_iorq", {15'd0, ack_iorq}, 16'd0);
        chk(req, "vec_load", {15'd0, vec_load}, 16'd0);
        chk(req, "halted", {15'd0, halted}, 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        drive('0);
        repeat (3) tick();
        rst = 1'b0;
        chk_idle("R1");

        for (int i = 0; i < NROWS; i++) begin
            string tag;
            drive(TBL[i].in);
            tick();
            tag = $sformatf("R%0d row%0d", TBL[i].req, i);
            chk(tag, "bus_ack", {15'd0, bus_ack}, {15'd0, TBL[i].ex[4]});
            chk(tag, "bus_oe", {15'd0, bus_oe}, {15'd0, ~TBL[i].ex[4]});
            chk(tag, "ack_m1", {15'd0, ack_m1}, {15'd0, TBL[i].ex[3]});
            chk(tag, "ack_iorq", {15'd0, ack_iorq}, {15'd0, TBL[i].ex[3]});
            chk(tag, "vec_load", {15'd0, vec_load}, {15'd0, TBL[i].ex[2]});
            chk(tag, "halted", {15'd0, halted}, {15'd0, TBL[i].ex[0]});
            if (TBL[i].ex[2])
                chk(tag, "vec_addr", vec_addr, TBL[i].ex[1] ? 16'h0066 : 16'h0038);
        end
        drive('0);
        tick();

        // R1: reset in the middle of activity clears pending nmi, flag and halt
        nmi_req = 1'b1; tick();
        nmi_req = 1'b0; ie_set = 1'b1; halt_cmd = 1'b1; tick();
        ie_set = 1'b0; halt_cmd = 1'b0;
        chk("R11", "halted", {15'd0, halted}, 16'd1);
        rst = 1'b1; tick(); tick();
        rst = 1'b0;
        chk_idle("R1");
        int_req = 1'b1; cyc_end = 1'b1; ins_end = 1'b1; tick();
        chk("R1", "ack_m1 after reset", {15'd0, ack_m1}, 16'd0);
        chk("R1", "vec_load after reset", {15'd0, vec_load}, 16'd0);
        drive('0); tick();
        chk("R1", "vec_load later", {15'd0, vec_load}, 16'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule